// File: doc/BRIEF.md
# Speculative Branch Mask Tracker

This block keeps track of the conditional branches that are still unresolved in a superscalar core, up to four at a time. Each unresolved branch occupies a slot, and the slot number is the branch's identifier. Every instruction that enters the speculative window receives a dependency mask with one bit per slot. A bit is set when the instruction was issued behind the branch that holds that slot. Each branch also records the mask that was current when it was allocated, so the tracker knows which branches are younger than which.

A branch resolves in one of two ways. If it was predicted correctly, the tracker broadcasts a clear of that branch's bit, so that live masks in the pipeline drop it and the slot becomes free. If it was mispredicted, the tracker broadcasts a kill of that bit. Every instruction whose mask contains the bit is then squashed, while results from the correct path are kept. The mispredicted slot is freed, and so is every younger branch that was issued behind it. Resolutions may arrive in any order. A resolution and an allocation in the same cycle are both handled, and the resolution takes effect first.

Top module: `spec_branch_tracker`

## Requirements
- R1: After a synchronous active-high reset, no slot is busy: `tag_mask` is 0, `alloc_full` is 0, and `kill_mask` and `clear_mask` are 0.
- R2: An allocation request is granted in the same cycle when a slot is free. `alloc_id` gives the lowest-numbered free slot, and that slot is busy from the next cycle on.
- R3: When all four slots are busy after this cycle's resolution, `alloc_full` is 1. A request is then refused (`alloc_grant` 0, `alloc_id` 0), and the busy set is left unchanged.
- R4: `tag_mask` has bit i set exactly when slot i is busy after this cycle's resolution. A branch granted in the same cycle is not included. A newly granted branch records this value as its own dependency mask.
- R5: A correct resolution of a busy slot drives `clear_mask` one-hot at that slot in the same cycle and frees the slot. It also removes that bit from the dependency mask of every other branch, so a later mispredict of a reused slot with the same number does not kill those branches.
- R6: A mispredict of a busy slot drives `kill_mask` one-hot at that slot. It frees that slot and every busy slot whose dependency mask has that bit. Slots that do not depend on it stay busy.
- R7: A resolution that names a slot that is not busy is ignored: both broadcasts stay 0 and the busy set does not change.
- R8: When a resolution and an allocation arrive in the same cycle, the resolution is applied first. A slot freed by it can be granted in that cycle, and the new branch's mask leaves out the resolved and killed bits.
- R9: `kill_mask` and `clear_mask` each have at most one bit set, and they are never both non-zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Request a slot for a new conditional branch |
| alloc_grant | output | 1 | The request is accepted this cycle |
| alloc_id | output | 2 | Slot given to the new branch (0 when not granted) |
| alloc_full | output | 1 | No slot free after this cycle's resolution |
| tag_mask | output | 4 | Dependency mask for instructions issued this cycle |
| resolve_valid | input | 1 | A branch outcome is presented |
| resolve_id | input | 2 | Slot of the branch being resolved |
| resolve_mispredict | input | 1 | 1 = prediction was wrong, 0 = correct |
| kill_mask | output | 4 | One-hot bit whose dependents must be squashed |
| clear_mask | output | 4 | One-hot bit to drop from all live masks |

## Verification
The hardest case to reach is a mispredict that must free a chain of younger branches while leaving alone a branch whose dependency on the same slot number was removed by an earlier correct resolution. The stimulus first fills all four slots. It then resolves a middle branch correctly and reallocates its slot as the youngest branch. It mispredicts an older branch and checks which slots are still busy through `tag_mask`. Later, it frees slot 0 correctly, reuses it as a branch younger than slot 1, and mispredicts it, checking that slot 1 survives. Other steps resolve and allocate in the same cycle, to show that resolution is applied before the grant.

// File: rtl/brm_pkg.sv
package brm_pkg;
    parameter int NUM_BR = 4;
    localparam int ID_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1;

    typedef logic [NUM_BR-1:0] br_mask_t;
    typedef logic [ID_W-1:0]   br_id_t;

    typedef struct packed {
        logic   valid;
        br_id_t id;
        logic   mispredict;
    } resolve_t;

    function automatic br_mask_t id_to_bit(input br_id_t id);
        br_mask_t m;
        m = '0;
        m[id] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/brm_resolve.sv
module brm_resolve
    import brm_pkg::*;
(
    input  br_mask_t busy,
    input  br_mask_t dep [NUM_BR],
    input  resolve_t res,
    output br_mask_t clear_mask,
    output br_mask_t kill_mask,
    output br_mask_t drop_mask
);
    logic     hit;
    br_mask_t younger;

    assign hit = res.valid && busy[res.id];

    for (genvar i = 0; i < NUM_BR; i++) begin : g_young
        assign younger[i] = busy[i] && dep[i][res.id];
    end

    always_comb begin
        clear_mask = '0;
        kill_mask  = '0;
        drop_mask  = '0;
        if (hit) begin
            if (res.mispredict) begin
                kill_mask = id_to_bit(res.id);
                drop_mask = id_to_bit(res.id) | younger;
            end else begin
                clear_mask = id_to_bit(res.id);
                drop_mask  = id_to_bit(res.id);
            end
        end
    end
endmodule

// File: rtl/brm_pick.sv
module brm_pick
    import brm_pkg::*;
(
    input  br_mask_t avail,
    output logic     found,
    output br_id_t   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_BR - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = br_id_t'(i);
            end
        end
    end
endmodule

// File: rtl/spec_branch_tracker.sv
module spec_branch_tracker
    import brm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       alloc_req,
    output logic       alloc_grant,
    output logic [1:0] alloc_id,
    output logic       alloc_full,
    output logic [3:0] tag_mask,
    input  logic       resolve_valid,
    input  logic [1:0] resolve_id,
    input  logic       resolve_mispredict,
    output logic [3:0] kill_mask,
    output logic [3:0] clear_mask
);
    br_mask_t busy_q;
    br_mask_t dep_q [NUM_BR];
    br_mask_t clr_w, kill_w, drop_w, busy_after;
    resolve_t res;
    logic     found;
    br_id_t   pick_idx;

    assign res = '{valid: resolve_valid, id: resolve_id, mispredict: resolve_mispredict};

    brm_resolve u_resolve (
        .busy       (busy_q),
        .dep        (dep_q),
        .res        (res),
        .clear_mask (clr_w),
        .kill_mask  (kill_w),
        .drop_mask  (drop_w)
    );

    assign busy_after = busy_q & ~drop_w;

    brm_pick u_pick (
        .avail (~busy_after),
        .found (found),
        .idx   (pick_idx)
    );

    assign alloc_grant = alloc_req && found;
    assign alloc_full  = !found;
    assign alloc_id    = alloc_grant ? pick_idx : '0;
    assign tag_mask    = busy_after;
    assign kill_mask   = kill_w;
    assign clear_mask  = clr_w;

    for (genvar i = 0; i < NUM_BR; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q[i] <= 1'b0;
                dep_q[i]  <= '0;
            end else if (alloc_grant && pick_idx == br_id_t'(i)) begin
                busy_q[i] <= 1'b1;
                dep_q[i]  <= busy_after;
            end else begin
                busy_q[i] <= busy_after[i];
                dep_q[i]  <= dep_q[i] & ~clr_w;
            end
        end
    end
endmodule

// File: rtl/brm_checker.sv
module brm_checker
    import brm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       alloc_grant,
    input logic [1:0] alloc_id,
    input logic       alloc_full,
    input logic [3:0] tag_mask,
    input logic       resolve_valid,
    input logic [1:0] resolve_id,
    input logic [3:0] kill_mask,
    input logic [3:0] clear_mask,
    input logic [3:0] busy
);
    assert_full_refuses_R3: assert property (@(posedge clk) disable iff (rst)
        alloc_full |-> !alloc_grant);

    assert_grant_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_grant |=> busy[$past(alloc_id)]);

    assert_tag_excludes_new_R4: assert property (@(posedge clk) disable iff (rst)
        alloc_grant |-> (tag_mask[alloc_id] == 1'b0));

    assert_clear_frees_R5: assert property (@(posedge clk) disable iff (rst)
        (|clear_mask && !alloc_grant) |=> ((busy & $past(clear_mask)) == 4'b0));

    assert_kill_not_tagged_R6: assert property (@(posedge clk) disable iff (rst)
        |kill_mask |-> ((tag_mask & kill_mask) == 4'b0));

    assert_idle_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (resolve_valid && !busy[resolve_id]) |-> (kill_mask == 4'b0 && clear_mask == 4'b0));

    assert_onehot_bcast_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(kill_mask) && $onehot0(clear_mask) && !(|kill_mask && |clear_mask));
endmodule

bind spec_branch_tracker brm_checker u_brm_checker (
    .clk           (clk),
    .rst           (rst),
    .alloc_grant   (alloc_grant),
    .alloc_id      (alloc_id),
    .alloc_full    (alloc_full),
    .tag_mask      (tag_mask),
    .resolve_valid (resolve_valid),
    .resolve_id    (resolve_id),
    .kill_mask     (kill_mask),
    .clear_mask    (clear_mask),
    .busy          (busy_q)
);

// File: tb/test_spec_branch_tracker.sv
module test_spec_branch_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_req = 1'b0;
    logic       alloc_grant;
    logic [1:0] alloc_id;
    logic       alloc_full;
    logic [3:0] tag_mask;
    logic       resolve_valid = 1'b0;
    logic [1:0] resolve_id = 2'd0;
    logic       resolve_mispredict = 1'b0;
    logic [3:0] kill_mask;
    logic [3:0] clear_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    spec_branch_tracker i_spec_branch_tracker (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_grant(alloc_grant),
        .alloc_id(alloc_id), .alloc_full(alloc_full), .tag_mask(tag_mask),
        .resolve_valid(resolve_valid), .resolve_id(resolve_id),
        .resolve_mispredict(resolve_mispredict), .kill_mask(kill_mask),
        .clear_mask(clear_mask)
    );

    // vector: {req, rv, rid[2], mis, grant, id[2], full, tag[4], kill[4], clr[4]}
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd0,1'b0,4'b0000,4'b0000,4'b0000}, // R2 first slot
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd1,1'b0,4'b0001,4'b0000,4'b0000}, // R2 R4
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd2,1'b0,4'b0011,4'b0000,4'b0000}, // R2 R4
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b0,4'b0111,4'b0000,4'b0000}, // R2 R4
        {1'b1,1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1,4'b1111,4'b0000,4'b0000}, // R3 full
        {1'b0,1'b1,2'd1,1'b0, 1'b0,2'd0,1'b0,4'b1101,4'b0000,4'b0010}, // R5 clear slot 1
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd1,1'b0,4'b1101,4'b0000,4'b0000}, // R2 reuse slot 1
        {1'b0,1'b1,2'd2,1'b1, 1'b0,2'd0,1'b0,4'b0001,4'b0100,4'b0000}, // R6 kill chain 2,3,1
        {1'b0,1'b1,2'd3,1'b1, 1'b0,2'd0,1'b0,4'b0001,4'b0000,4'b0000}, // R7 idle slot
        {1'b1,1'b1,2'd0,1'b0, 1'b1,2'd0,1'b0,4'b0000,4'b0000,4'b0001}, // R8 clear+alloc
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd1,1'b0,4'b0001,4'b0000,4'b0000}, // R2
        {1'b1,1'b1,2'd0,1'b1, 1'b1,2'd0,1'b0,4'b0000,4'b0001,4'b0000}, // R8 kill+alloc
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd1,1'b0,4'b0001,4'b0000,4'b0000}, // R2
        {1'b0,1'b1,2'd0,1'b0, 1'b0,2'd0,1'b0,4'b0010,4'b0000,4'b0001}, // R5 clear slot 0
        {1'b1,1'b0,2'd0,1'b0, 1'b1,2'd0,1'b0,4'b0010,4'b0000,4'b0000}, // R4 younger in slot 0
        {1'b0,1'b1,2'd0,1'b1, 1'b0,2'd0,1'b0,4'b0010,4'b0001,4'b0000}, // R5 R6 slot 1 survives
        {1'b0,1'b1,2'd1,1'b0, 1'b0,2'd0,1'b0,4'b0000,4'b0000,4'b0010}  // R5 empty again
    };
    localparam int VREQ [NV] = '{2,4,4,4,3,5,2,6,7,8,2,8,2,5,4,5,5};

    task automatic chk(input string what, input int rq, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%b expected=%b", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic rv, input logic [1:0] rid, input logic mis);
        @(negedge clk);
        alloc_req = a; resolve_valid = rv; resolve_id = rid; resolve_mispredict = mis;
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("reset tag", 1, {4'b0, tag_mask}, 8'd0);
        chk("reset full", 1, {7'b0, alloc_full}, 8'd0);
        chk("reset bcast", 1, {kill_mask, clear_mask}, 8'd0);

        for (int v = 0; v < NV; v++) begin
            logic [20:0] e;
            e = VEC[v];
            drive(e[20], e[19], e[18:17], e[16]);
            chk($sformatf("v%0d grant", v), VREQ[v], {7'b0, alloc_grant}, {7'b0, e[15]});
            chk($sformatf("v%0d id", v),    VREQ[v], {6'b0, alloc_id},    {6'b0, e[14:13]});
            chk($sformatf("v%0d full", v),  VREQ[v], {7'b0, alloc_full},  {7'b0, e[12]});
            chk($sformatf("v%0d tag", v),   VREQ[v], {4'b0, tag_mask},    {4'b0, e[11:8]});
            chk($sformatf("v%0d kill", v),  VREQ[v], {4'b0, kill_mask},   {4'b0, e[7:4]});
            chk($sformatf("v%0d clear", v), VREQ[v], {4'b0, clear_mask},  {4'b0, e[3:0]});
        end

        // R3: full with resolve of a busy slot frees it for same-cycle grant (R8)
        for (int k = 0; k < 4; k++) drive(1'b1, 1'b0, 2'd0, 1'b0);
        drive(1'b1, 1'b1, 2'd2, 1'b0);
        chk("full+clear grant", 8, {7'b0, alloc_grant}, 8'd1);
        chk("full+clear id", 8, {6'b0, alloc_id}, 8'd2);
        chk("full+clear tag", 8, {4'b0, tag_mask}, 8'b1011);
        drive(1'b0, 1'b0, 2'd0, 1'b0);
        chk("refilled full", 3, {7'b0, alloc_full}, 8'd1);
        // R1 reset mid-run clears everything
        @(negedge clk); rst = 1'b1; alloc_req = 1'b0;
        @(negedge clk); rst = 1'b0; #2;
        chk("reset again tag", 1, {4'b0, tag_mask}, 8'd0);
        chk("reset again full", 1, {7'b0, alloc_full}, 8'd0);
        drive(1'b1, 1'b0, 2'd0, 1'b0);
        chk("post reset id", 2, {6'b0, alloc_id}, 8'd0);
        drive(1'b0, 1'b0, 2'd0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL R1 watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule